// File: doc/BRIEF.md
# Two-Phase Addressed DRAM Core with Open-Row Buffer

This block is a synthesizable behavioural model of a small DRAM array whose words ("supercells") sit in a square grid of rows and columns. A single narrow address bus is shared in time. During a row strobe it carries the row index. During a column strobe it carries the column index. A row strobe copies the whole selected row into an internal row buffer. Every later column strobe then reads or writes one supercell of that buffer. Several column strobes after one row strobe form a page-mode burst, with no new row access needed.

The buffer goes back into the array when the row is closed by a precharge, or when a row strobe opens a different row. A row strobe that names the row already open keeps the buffer as it is, so edits are not lost. Only one command takes effect per cycle. A column strobe issued while no row is open does nothing except raise a one-cycle error flag. Array contents are undefined after reset, so a user fills the array by writes before reading it.

Top module: `dram_page_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `row_open`, `rvalid` and `err` are 0 and `rdata` is 0. Array contents are not defined by reset.
- R2: A row strobe (`ras`=1, row index on `addr`) sets `row_open` to 1 on the next cycle and loads the addressed row into the row buffer.
- R3: A read column strobe (`cas`=1, `we`=0, column index on `addr`) to an open row drives that supercell on `rdata` with `rvalid`=1 one clock later. Both stay unchanged until the next `ras`, `pre` or `cas`, and any of these clears `rvalid` unless it is itself an accepted read.
- R4: Consecutive read column strobes with no row strobe between them each return the supercell of the open row that their column index selects.
- R5: A write column strobe (`cas`=1, `we`=1) to an open row stores `wdata` into the addressed supercell of the buffer, clears `rvalid` on the next cycle and leaves `rdata` unchanged. A later read of that column returns the new value.
- R6: A precharge (`pre`=1) writes the open row's buffer back to the array and sets `row_open` to 0 on the next cycle. Reopening that row later returns the data written before the precharge.
- R7: A row strobe while another row is open first writes the old row back to the array, so a later reopen of the old row returns its edited contents.
- R8: A column strobe while no row is open changes no supercell, sets `err` to 1 for exactly the next cycle and clears `rvalid`. `err` is 0 in every other cycle.
- R9: When strobes coincide, `ras` wins over `pre` and `pre` wins over `cas`. The losing strobes are ignored entirely, including their write data.
- R10: A row strobe that names the row already open keeps the buffer contents, including unwritten-back edits.
- R11: A precharge while no row is open changes no array contents and only clears `rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ras | input | 1 | Row strobe: open the row on `addr` |
| cas | input | 1 | Column strobe: access the column on `addr` |
| we | input | 1 | With `cas`: 1 writes, 0 reads |
| pre | input | 1 | Precharge: write back and close the open row |
| addr | input | ADDR_W | Shared row / column index |
| wdata | input | WORD_W | Supercell to write |
| rdata | output | WORD_W | Supercell read, registered |
| rvalid | output | 1 | `rdata` holds the result of the last column read |
| err | output | 1 | One-cycle pulse for a column strobe with no open row |
| row_open | output | 1 | A row is held in the row buffer |

## Verification
The bench builds the block with its default parameters, 2 address pins and 8-bit supercells, which gives a 4 x 4 grid of 16 cells. At that size every row and every column can be written with a distinct value and read back. This covers full-row write-back on both precharge and row switch, reopening the same row, and every collision of strobes. A behavioural model keeps the array and the open row as plain integer arrays, and it is compared with all four outputs on every clock.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_OPEN,
    CMD_CLOSE,
    CMD_READ,
    CMD_WRITE,
    CMD_BAD
  } dram_cmd_e;
endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_pkg::*;
(
  input  logic      ras,
  input  logic      cas,
  input  logic      we,
  input  logic      pre,
  input  logic      row_open,
  output dram_cmd_e cmd,
  output logic      wb_en
);
  // one command per cycle: row strobe, then precharge, then column strobe
  always_comb begin
    if (ras)           cmd = CMD_OPEN;
    else if (pre)      cmd = CMD_CLOSE;
    else if (cas) begin
      if (!row_open)   cmd = CMD_BAD;
      else if (we)     cmd = CMD_WRITE;
      else             cmd = CMD_READ;
    end
    else               cmd = CMD_IDLE;
  end

  // the open row goes back to the array whenever it is being left
  assign wb_en = row_open && (ras || pre);
endmodule

// File: rtl/dram_array.sv
module dram_array #(
  parameter int ADDR_W = 2,
  parameter int ROW_W  = 32
) (
  input  logic              clk,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_row,
  input  logic [ROW_W-1:0]  wb_data,
  input  logic [ADDR_W-1:0] rd_row,
  output logic [ROW_W-1:0]  rd_data
);
  localparam int NROWS = 1 << ADDR_W;

  // whole rows per entry: one write and one read per row activation
  logic [ROW_W-1:0] mem [NROWS];

  always_ff @(posedge clk) begin
    if (wb_en) mem[wb_row] <= wb_data;
  end

  assign rd_data = mem[rd_row];
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        open_cmd,
  input  logic                        close_cmd,
  input  logic                        wr_cmd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [(WORD_W<<ADDR_W)-1:0] load_data,
  output logic                        row_open,
  output logic [ADDR_W-1:0]           open_row,
  output logic [(WORD_W<<ADDR_W)-1:0] row_data,
  output logic [WORD_W-1:0]           sel_word
);
  localparam int NCOLS = 1 << ADDR_W;

  logic same_row;
  logic load;

  assign same_row = row_open && (open_row == addr);
  assign load     = open_cmd && !same_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (open_cmd) begin
      row_open <= 1'b1;
      open_row <= addr;
    end else if (close_cmd) begin
      row_open <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_cell
    logic [WORD_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (load)
        cell_q <= load_data[c*WORD_W +: WORD_W];
      else if (wr_cmd && (addr == ADDR_W'(c)))
        cell_q <= wdata;
    end
    assign row_data[c*WORD_W +: WORD_W] = cell_q;
  end

  assign sel_word = row_data[addr*WORD_W +: WORD_W];
endmodule

// File: rtl/dram_col_port.sv
module dram_col_port
  import dram_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dram_cmd_e         cmd,
  input  logic [WORD_W-1:0] sel_word,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= (cmd == CMD_BAD);
      if (cmd == CMD_READ) begin
        rdata  <= sel_word;
        rvalid <= 1'b1;
      end else if (cmd != CMD_IDLE) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_page_core.sv
module dram_page_core
  import dram_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras,
  input  logic              cas,
  input  logic              we,
  input  logic              pre,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              err,
  output logic              row_open
);
  localparam int ROW_W = WORD_W << ADDR_W;

  dram_cmd_e         cmd;
  logic              wb_en;
  logic [ADDR_W-1:0] open_row;
  logic [ROW_W-1:0]  buf_row;
  logic [ROW_W-1:0]  arr_row;
  logic [WORD_W-1:0] sel_word;

  dram_cmd_decode u_dec (
    .ras      (ras),
    .cas      (cas),
    .we       (we),
    .pre      (pre),
    .row_open (row_open),
    .cmd      (cmd),
    .wb_en    (wb_en)
  );

  dram_array #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_arr (
    .clk     (clk),
    .wb_en   (wb_en),
    .wb_row  (open_row),
    .wb_data (buf_row),
    .rd_row  (addr),
    .rd_data (arr_row)
  );

  dram_row_buffer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .open_cmd  (cmd == CMD_OPEN),
    .close_cmd (cmd == CMD_CLOSE),
    .wr_cmd    (cmd == CMD_WRITE),
    .addr      (addr),
    .wdata     (wdata),
    .load_data (arr_row),
    .row_open  (row_open),
    .open_row  (open_row),
    .row_data  (buf_row),
    .sel_word  (sel_word)
  );

  dram_col_port #(.WORD_W(WORD_W)) u_col (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .sel_word (sel_word),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .err      (err)
  );
endmodule

// File: rtl/dram_page_core_chk.sv
module dram_page_core_chk #(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ras,
  input logic              cas,
  input logic              we,
  input logic              pre,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid,
  input logic              err,
  input logic              row_open
);
  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    ras |=> row_open);

  p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (cas && !we && !ras && !pre && row_open) |=> rvalid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !ras && !pre && !cas) |=> (rvalid && $stable(rdata)));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (cas && we && !ras && !pre && row_open) |=> (!rvalid && $stable(rdata)));

  p_close_r6: assert property (@(posedge clk) disable iff (rst)
    (pre && !ras) |=> !row_open);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (cas && !ras && !pre && !row_open) |=> (err && !rvalid));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!cas || ras || pre || row_open) |=> !err);
endmodule

bind dram_page_core dram_page_core_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ras      (ras),
  .cas      (cas),
  .we       (we),
  .pre      (pre),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .err      (err),
  .row_open (row_open)
);

// File: tb/dram_page_core_bench.sv
module dram_page_core_bench;
  localparam int ADDR_W = 2;
  localparam int WORD_W = 8;
  localparam int N      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ras = 1'b0, cas = 1'b0, we = 1'b0, pre = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic              rvalid, err, row_open;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int mem_m [N][N];
  int buf_m [N];
  int open_m = 0, row_m = 0, rdata_m = 0, rvalid_m = 0, err_m = 0;

  always #10 clk = ~clk;

  dram_page_core #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dram_page_core (
    .clk(clk), .rst(rst), .ras(ras), .cas(cas), .we(we), .pre(pre),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .err(err), .row_open(row_open)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "row_open", int'(row_open), open_m);
    chk(tag, "rvalid",   int'(rvalid),   rvalid_m);
    chk(tag, "err",      int'(err),      err_m);
    chk(tag, "rdata",    int'(rdata),    rdata_m);
  endtask

  task automatic writeback();
    for (int c = 0; c < N; c++) mem_m[row_m][c] = buf_m[c];
  endtask

  // drive one cycle, update the model for the edge, compare at the next negedge
  task automatic step(input bit r, input bit c, input bit w, input bit p,
                      input int a, input int d, input string tag);
    ras = r; cas = c; we = w; pre = p; addr = a[ADDR_W-1:0]; wdata = d[WORD_W-1:0];
    @(posedge clk);
    err_m = 0;
    if (r) begin
      if (open_m) writeback();
      if (!(open_m && row_m == a))
        for (int k = 0; k < N; k++) buf_m[k] = mem_m[a][k];
      open_m = 1; row_m = a; rvalid_m = 0;
    end else if (p) begin
      if (open_m) writeback();
      open_m = 0; rvalid_m = 0;
    end else if (c) begin
      if (!open_m) begin err_m = 1; rvalid_m = 0; end
      else if (w) begin buf_m[a] = d; rvalid_m = 0; end
      else begin rdata_m = buf_m[a]; rvalid_m = 1; end
    end
    @(negedge clk);
    ras = 0; cas = 0; we = 0; pre = 0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");                       // outputs held in reset
    rst = 0;
    idle("R1");

    // fill every cell with a distinct value
    for (int r = 0; r < N; r++) begin
      step(1, 0, 0, 0, r, 0, "R2");
      for (int c = 0; c < N; c++) step(0, 1, 1, 0, c, r*16 + c*3 + 1, "R5");
      step(0, 0, 0, 1, 0, 0, "R6");
    end

    // page-mode burst and hold
    step(1, 0, 0, 0, 2, 0, "R2");
    for (int c = 0; c < N; c++) step(0, 1, 0, 0, c, 0, "R4");
    idle("R3"); idle("R3");
    step(0, 1, 0, 0, 3, 0, "R4");
    step(0, 1, 0, 0, 0, 0, "R4");

    // write in open row then read back
    step(0, 1, 1, 0, 1, 8'hA7, "R5");
    idle("R5");
    step(0, 1, 0, 0, 1, 0, "R5");

    // row switch writes back the edited row
    step(1, 0, 0, 0, 1, 0, "R7");
    step(0, 1, 0, 0, 2, 0, "R7");
    step(1, 0, 0, 0, 2, 0, "R7");
    step(0, 1, 0, 0, 1, 0, "R7");

    // reopen after precharge
    step(0, 1, 1, 0, 3, 8'h3C, "R6");
    step(0, 0, 0, 1, 0, 0, "R6");
    step(1, 0, 0, 0, 2, 0, "R6");
    step(0, 1, 0, 0, 3, 0, "R6");
    step(0, 0, 0, 1, 0, 0, "R6");

    // column strobes with no open row
    step(0, 1, 0, 0, 0, 0, "R8");
    idle("R8");
    step(0, 1, 1, 0, 0, 8'hEE, "R8");
    step(0, 1, 1, 0, 0, 8'hEE, "R8");
    idle("R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 0, "R8");

    // coinciding strobes
    step(1, 1, 1, 0, 3, 8'h99, "R9");
    step(0, 1, 0, 0, 3, 0, "R9");
    step(0, 1, 1, 1, 3, 8'h55, "R9");
    step(1, 1, 1, 1, 3, 8'h66, "R9");
    step(0, 1, 0, 0, 3, 0, "R9");
    step(0, 1, 0, 0, 0, 0, "R9");

    // same-row reopen keeps edits
    step(1, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 1, 0, 2, 8'h5A, "R10");
    step(1, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 2, 0, "R10");

    // precharge with nothing open
    step(0, 0, 0, 1, 0, 0, "R11");
    step(0, 0, 0, 1, 0, 0, "R11");
    idle("R11");
    step(1, 0, 0, 0, 0, 0, "R11");
    for (int c = 0; c < N; c++) step(0, 1, 0, 0, c, 0, "R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule